// File: doc/BRIEF.md
# Segmented LRU Instruction Cache

This block sits between an instruction fetch unit and slow external memory. The fetch unit presents one word address at a time. Addresses below a fixed internal-memory limit are not cached: the block only flags them as internal so the fetch unit reads its own fast memory. An external address that is present in the cache returns its instruction word on the next cycle. An external address that is not present is requested from external memory, passed back to the fetch unit, and written into the cache on the way.

Storage is 128 words, split into four segments of 32 words. Each segment holds one tag for a 32-word-aligned block and one valid bit per word, so a segment fills word by word as code runs through it. When a new block needs room, the least recently used segment is chosen. Software can lock any segment through a freeze mask, taken from a status register. A locked segment keeps its contents. A flush input drops every cached word.

Top module: `icache_seg`

## Requirements
- R1: After reset, `fetch_valid`, `fetch_hit`, `fetch_int`, `ext_req` and `busy` are low, every segment is empty, and cold misses allocate segments in the order 0, 1, 2, 3.
- R2: A request with `fetch_addr` below `INT_LIMIT` (0x1000) raises `fetch_int` for one cycle on the next cycle. It raises neither `ext_req` nor `fetch_valid` and leaves the cache unchanged.
- R3: A request whose block tag (`fetch_addr[23:5]`) is held by a segment that has the word (`fetch_addr[4:0]`) marked valid raises `fetch_valid` and `fetch_hit` on the next cycle, with the cached word on `fetch_data`.
- R4: On a miss, `ext_req` rises on the next cycle with `ext_addr` equal to the request address. Both hold until `ext_ack`. On the cycle after `ext_ack`, `fetch_valid` is high, `fetch_hit` is low and `fetch_data` equals `ext_rdata`.
- R5: Valid bits are kept per word. A word not yet fetched misses even when its block is resident and is then filled into that same segment. Taking a segment for a new tag clears all of its other valid bits.
- R6: Every hit and every allocation makes that segment the most recent. A miss on a non-resident block replaces the least recently used segment among those not frozen.
- R7: A segment whose bit in `freeze` is 1 is never replaced and never written.
- R8: When every segment is frozen, or the resident segment of the missing word is frozen, the miss is served from external memory and the cache is not updated, so a repeat of that request misses again.
- R9: A one-cycle `flush` pulse makes every later external request miss until the word is fetched again.
- R10: While a miss is outstanding, `busy` is high and `fetch_req` is ignored. No second external request is made and no extra response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached words |
| freeze | input | 4 | Per-segment lock mask from the status register |
| fetch_req | input | 1 | Fetch request strobe |
| fetch_addr | input | 24 | Word address of the fetch |
| busy | output | 1 | A miss is outstanding |
| fetch_valid | output | 1 | `fetch_data` carries the requested word |
| fetch_hit | output | 1 | The returned word came from the cache |
| fetch_int | output | 1 | The request was routed to internal memory |
| fetch_data | output | 32 | Returned instruction word |
| ext_req | output | 1 | External memory read request |
| ext_addr | output | 24 | External read address |
| ext_ack | input | 1 | External read completes this cycle |
| ext_rdata | input | 32 | External read data |

## Verification
The bench goes through a scripted sequence in which the LRU order is known at every step. It hits a block just before a new block needs room, so a design that evicts by fill order or round-robin would throw out a block still in use. It reuses an evicted segment at a different word offset, so a design that keeps stale valid bits would return the old block's data as a hit. It freezes the oldest segment and then all segments, so a design that ignores the mask would lose the locked block or hit on a word it should not have stored. It also fires a flush, and sends a request while a miss is pending, which a careless design would turn into a second external read.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } ic_state_t;
endpackage

// File: rtl/icache_lru.sv
// Age-based LRU tracker: age 0 is most recent, SEGS-1 is oldest.
module icache_lru #(
  parameter int SEGS  = 4,
  parameter int SEG_W = $clog2(SEGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [SEG_W-1:0] touch_seg,
  input  logic [SEGS-1:0]  freeze,
  output logic [SEG_W-1:0] victim_seg,
  output logic             victim_ok
);
  logic [SEG_W-1:0] age [SEGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SEGS; i++) age[i] <= SEG_W'(SEGS - 1 - i);
    end else if (touch_en) begin
      for (int i = 0; i < SEGS; i++) begin
        if (SEG_W'(i) == touch_seg)   age[i] <= '0;
        else if (age[i] < age[touch_seg]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_seg = '0;
    victim_ok  = 1'b0;
    for (int i = 0; i < SEGS; i++) begin
      if (!freeze[i] && (!victim_ok || age[i] > age[victim_seg])) begin
        victim_seg = SEG_W'(i);
        victim_ok  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/icache_tags.sv
// Per-segment tag, ownership flag and per-word valid bits.
module icache_tags #(
  parameter int SEGS      = 4,
  parameter int SEG_WORDS = 32,
  parameter int TAG_W     = 19,
  parameter int SEG_W     = $clog2(SEGS),
  parameter int OFF_W     = $clog2(SEG_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [OFF_W-1:0] lk_off,
  output logic [SEGS-1:0]  tag_hit,
  output logic [SEGS-1:0]  word_hit,
  input  logic             wr_en,
  input  logic             wr_new,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [OFF_W-1:0] wr_off
);
  logic [TAG_W-1:0]     tag_q [SEGS];
  logic [SEGS-1:0]      own_q;
  logic [SEG_WORDS-1:0] vb_q  [SEGS];

  genvar g;
  generate
    for (g = 0; g < SEGS; g++) begin : g_seg
      assign tag_hit[g]  = own_q[g] && (tag_q[g] == lk_tag);
      assign word_hit[g] = tag_hit[g] && vb_q[g][lk_off];

      always_ff @(posedge clk) begin
        if (rst) begin
          tag_q[g] <= '0;
          own_q[g] <= 1'b0;
          vb_q[g]  <= '0;
        end else begin
          if (wr_en && wr_seg == SEG_W'(g)) tag_q[g] <= wr_tag;
          if (flush) begin
            own_q[g] <= 1'b0;
            vb_q[g]  <= '0;
          end else if (wr_en && wr_seg == SEG_W'(g)) begin
            own_q[g] <= 1'b1;
            if (wr_new) vb_q[g] <= SEG_WORDS'(1) << wr_off;
            else        vb_q[g] <= vb_q[g] | (SEG_WORDS'(1) << wr_off);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/icache_dram.sv
// Simple dual-port word store, registered read, no reset (block RAM style).
module icache_dram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wa,
  input  logic [DATA_W-1:0] wd,
  input  logic              re,
  input  logic [IDX_W-1:0]  ra,
  output logic [DATA_W-1:0] rq
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/icache_seg.sv
module icache_seg #(
  parameter int                ADDR_W    = 24,
  parameter int                DATA_W    = 32,
  parameter int                SEGS      = 4,
  parameter int                SEG_WORDS = 32,
  parameter logic [ADDR_W-1:0] INT_LIMIT = 'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [SEGS-1:0]   freeze,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              busy,
  output logic              fetch_valid,
  output logic              fetch_hit,
  output logic              fetch_int,
  output logic [DATA_W-1:0] fetch_data,
  output logic              ext_req,
  output logic [ADDR_W-1:0] ext_addr,
  input  logic              ext_ack,
  input  logic [DATA_W-1:0] ext_rdata
);
  import icache_pkg::*;

  localparam int SEG_W = $clog2(SEGS);
  localparam int OFF_W = $clog2(SEG_WORDS);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = SEG_W + OFF_W;
  localparam int DEPTH = SEGS * SEG_WORDS;

  ic_state_t         state_q;
  logic [SEG_W-1:0]  mseg_q;
  logic              malloc_q, mnew_q;
  logic              valid_q, hit_q, int_q;
  logic [DATA_W-1:0] fill_q, ram_q;

  logic [TAG_W-1:0]  req_tag, ext_tag;
  logic [OFF_W-1:0]  req_off, ext_off;
  logic [SEGS-1:0]   tag_hit, word_hit;
  logic [SEG_W-1:0]  hit_seg, tag_seg, victim_seg;
  logic              victim_ok, accept, is_int, do_hit, do_miss, fill_done, fill_wr;

  assign req_tag   = fetch_addr[ADDR_W-1:OFF_W];
  assign req_off   = fetch_addr[OFF_W-1:0];
  assign ext_tag   = ext_addr[ADDR_W-1:OFF_W];
  assign ext_off   = ext_addr[OFF_W-1:0];

  assign accept    = fetch_req && (state_q == ST_IDLE);
  assign is_int    = fetch_addr < INT_LIMIT;
  assign do_hit    = accept && !is_int && (|word_hit);
  assign do_miss   = accept && !is_int && !(|word_hit);
  assign fill_done = (state_q == ST_FILL) && ext_ack;
  assign fill_wr   = fill_done && malloc_q && !freeze[mseg_q];

  always_comb begin
    hit_seg = '0;
    tag_seg = '0;
    for (int i = 0; i < SEGS; i++) begin
      if (word_hit[i]) hit_seg = SEG_W'(i);
      if (tag_hit[i])  tag_seg = SEG_W'(i);
    end
  end

  icache_tags #(.SEGS(SEGS), .SEG_WORDS(SEG_WORDS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_tag(req_tag), .lk_off(req_off),
    .tag_hit(tag_hit), .word_hit(word_hit),
    .wr_en(fill_wr), .wr_new(mnew_q), .wr_seg(mseg_q),
    .wr_tag(ext_tag), .wr_off(ext_off)
  );

  icache_lru #(.SEGS(SEGS)) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(do_hit || fill_wr),
    .touch_seg(do_hit ? hit_seg : mseg_q),
    .freeze(freeze),
    .victim_seg(victim_seg), .victim_ok(victim_ok)
  );

  icache_dram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk),
    .we(fill_wr), .wa({mseg_q, ext_off}), .wd(ext_rdata),
    .re(do_hit), .ra({hit_seg, req_off}), .rq(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ext_req  <= 1'b0;
      ext_addr <= '0;
      mseg_q   <= '0;
      malloc_q <= 1'b0;
      mnew_q   <= 1'b0;
      valid_q  <= 1'b0;
      hit_q    <= 1'b0;
      int_q    <= 1'b0;
      fill_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      int_q   <= 1'b0;
      if (accept && is_int) int_q <= 1'b1;
      if (do_hit) begin
        valid_q <= 1'b1;
        hit_q   <= 1'b1;
      end
      if (do_miss) begin
        state_q  <= ST_FILL;
        ext_req  <= 1'b1;
        ext_addr <= fetch_addr;
        if (|tag_hit) begin
          mseg_q   <= tag_seg;
          malloc_q <= !freeze[tag_seg];
          mnew_q   <= 1'b0;
        end else begin
          mseg_q   <= victim_seg;
          malloc_q <= victim_ok;
          mnew_q   <= 1'b1;
        end
      end
      if (fill_done) begin
        state_q <= ST_IDLE;
        ext_req <= 1'b0;
        valid_q <= 1'b1;
        hit_q   <= 1'b0;
        fill_q  <= ext_rdata;
      end
    end
  end

  assign busy        = (state_q == ST_FILL);
  assign fetch_valid = valid_q;
  assign fetch_hit   = valid_q && hit_q;
  assign fetch_int   = int_q;
  assign fetch_data  = hit_q ? ram_q : fill_q;
endmodule

// File: rtl/icache_seg_chk.sv
module icache_seg_chk #(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] INT_LIMIT = 'h1000
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              busy,
  input logic              fetch_valid,
  input logic              fetch_hit,
  input logic              fetch_int,
  input logic              ext_req,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ext_ack
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fetch_valid && !fetch_int && !ext_req && !busy);

  // R2
  int_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req && !busy && (fetch_addr < INT_LIMIT) |=> fetch_int && !fetch_valid && !ext_req);

  // R3
  hit_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_hit |-> fetch_valid && !fetch_int);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ext_req && !ext_ack |=> ext_req && $stable(ext_addr));

  // R4
  fill_return_chk: assert property (@(posedge clk) disable iff (rst)
    ext_req && ext_ack |=> fetch_valid && !fetch_hit && !ext_req);

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !fetch_valid && !fetch_int);
endmodule

bind icache_seg icache_seg_chk #(.ADDR_W(ADDR_W), .INT_LIMIT(INT_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
  .busy(busy), .fetch_valid(fetch_valid), .fetch_hit(fetch_hit),
  .fetch_int(fetch_int), .ext_req(ext_req), .ext_addr(ext_addr), .ext_ack(ext_ack)
);

// File: tb/sim_icache_seg.sv
`timescale 1ns/1ps
module sim_icache_seg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [3:0]  freeze = 4'h0;
  logic        fetch_req = 1'b0;
  logic [23:0] fetch_addr = '0;
  logic        busy, fetch_valid, fetch_hit, fetch_int;
  logic [31:0] fetch_data;
  logic        ext_req;
  logic [23:0] ext_addr;
  logic        ext_ack = 1'b0;
  logic [31:0] ext_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  icache_seg u0 (
    .clk(clk), .rst(rst), .flush(flush), .freeze(freeze),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .busy(busy), .fetch_valid(fetch_valid), .fetch_hit(fetch_hit),
    .fetch_int(fetch_int), .fetch_data(fetch_data),
    .ext_req(ext_req), .ext_addr(ext_addr),
    .ext_ack(ext_ack), .ext_rdata(ext_rdata)
  );

  function automatic logic [31:0] word_of(input logic [23:0] a);
    return {8'hC3, a} ^ 32'h0005_A000;
  endfunction

  // external memory: acknowledges two cycles after a request is seen
  int lat = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (ext_ack) begin
        ext_ack = 1'b0;
      end else if (ext_req) begin
        if (lat == 2) begin
          ext_ack   = 1'b1;
          ext_rdata = word_of(ext_addr);
          lat = 0;
        end else lat++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one fetch; reports how it was answered
  task automatic fetch(input logic [23:0] a, output bit v, output bit h,
                       output bit i, output bit m, output logic [31:0] d,
                       output logic [23:0] ea);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
    i = fetch_int; m = ext_req; ea = ext_addr;
    v = fetch_valid; h = fetch_hit; d = fetch_data;
    if (m) begin
      for (int n = 0; n < 100 && !fetch_valid; n++) @(negedge clk);
      v = fetch_valid; h = fetch_hit; d = fetch_data;
    end
  endtask

  task automatic expect_hit(input logic [23:0] a, input string req);
    bit v, h, i, m; logic [31:0] d; logic [23:0] ea;
    fetch(a, v, h, i, m, d, ea);
    check(v && h && !m && !i, req, $sformatf("hit flags @%h", a), {28'd0, v, h, i, m}, 32'hC);
    check(d == word_of(a), req, $sformatf("hit data @%h", a), d, word_of(a));
  endtask

  task automatic expect_miss(input logic [23:0] a, input string req);
    bit v, h, i, m; logic [31:0] d; logic [23:0] ea;
    fetch(a, v, h, i, m, d, ea);
    check(v && !h && m && !i && ea == a, req, $sformatf("miss flags/addr @%h", a),
          {4'd0, ea, v, h, i, m}, {4'd0, a, 4'b1001});
    check(d == word_of(a), req, $sformatf("miss data @%h", a), d, word_of(a));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!fetch_valid && !fetch_hit && !fetch_int && !ext_req && !busy, "R1", "idle outputs",
          {27'd0, fetch_valid, fetch_hit, fetch_int, ext_req, busy}, 32'd0);
  endtask

  task automatic t_internal();
    bit v, h, i, m; logic [31:0] d; logic [23:0] ea;
    for (int k = 0; k < 2; k++) begin
      fetch(24'h000040, v, h, i, m, d, ea);
      check(i && !v && !m, "R2", "internal bypass", {29'd0, i, v, m}, 32'h4);
    end
  endtask

  task automatic t_fill_and_words();
    expect_miss(24'h002005, "R4");
    expect_hit (24'h002005, "R3");
    expect_miss(24'h002006, "R5");   // resident block, word not yet valid
    expect_hit (24'h002006, "R5");
  endtask

  task automatic t_lru();
    expect_miss(24'h003000, "R1");   // seg1
    expect_miss(24'h003001, "R5");
    expect_miss(24'h004000, "R1");   // seg2
    expect_miss(24'h005000, "R1");   // seg3
    expect_hit (24'h002005, "R6");   // seg0 becomes most recent
    expect_miss(24'h006003, "R6");   // replaces seg1 (block 0x3000)
    expect_miss(24'h006000, "R5");   // old valid bit of that segment cleared
    expect_hit (24'h002005, "R6");
    expect_hit (24'h004000, "R6");
  endtask

  task automatic t_freeze();
    // order now, oldest first: seg3(0x5000), seg1(0x6000), seg0(0x2000), seg2(0x4000)
    freeze = 4'b1000;
    expect_miss(24'h007000, "R7");   // seg3 frozen: seg1 replaced instead
    expect_hit (24'h005000, "R7");   // frozen block kept
    expect_miss(24'h006000, "R6");   // evicted block misses
    freeze = 4'b1111;
    expect_miss(24'h008000, "R8");
    expect_miss(24'h008000, "R8");   // not stored
    expect_miss(24'h005001, "R8");   // resident frozen segment not filled
    expect_miss(24'h005001, "R8");
    expect_hit (24'h005000, "R8");
    freeze = 4'b0000;
  endtask

  task automatic t_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    expect_miss(24'h005000, "R9");
    expect_miss(24'h002005, "R9");
    expect_hit (24'h005000, "R9");
  endtask

  task automatic t_busy();
    int extra = 0;
    @(negedge clk); fetch_req = 1'b1; fetch_addr = 24'h009000;
    @(negedge clk); fetch_req = 1'b0;
    check(busy && ext_req, "R10", "busy during miss", {30'd0, busy, ext_req}, 32'h3);
    fetch_req = 1'b1; fetch_addr = 24'h00A000;
    @(negedge clk); fetch_req = 1'b0;
    for (int n = 0; n < 100 && !fetch_valid; n++) @(negedge clk);
    check(fetch_valid && fetch_data == word_of(24'h009000), "R10", "first miss returned",
          fetch_data, word_of(24'h009000));
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (ext_req || fetch_valid || busy) extra++;
    end
    check(extra == 0, "R10", "request during busy ignored", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_internal();
    t_fill_and_words();
    t_lru();
    t_freeze();
    t_flush();
    t_busy();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule